// File: doc/BRIEF.md
# Selectable Beam Damper Kick Output Stage

This block turns a per-bunch signed orbit deviation into a 10-bit kick code for the damper DAC. It also produces a second code of equal magnitude and opposite sign, so the amplifier pair can push and pull on the beam. One new bunch sample arrives on every RF clock. Four output laws are available: a straight copy of the deviation, a scaled copy through an unsigned fixed-point gain, a bang-bang law that kicks at full scale, and a bang-bang law with a deadband around zero. When the bunch sum signal is below a cutoff there is no beam to act on, and the kick is held at zero.

The computed kick passes through a delay line of 0 to 31 RF clocks, so that the kick meets the bunch it was measured on. Two law selections are held at the same time. A pulse at the start of each accelerator cycle starts a timer. Once the programmed time has passed, the second selection replaces the first for the rest of that cycle.

Top module: `kick_law_stage`

## Requirements
- R1: With law code 0 (direct), the kick equals the deviation clamped to the signed 10-bit range [-512, 511].
- R2: With law code 1 (scaled), the kick equals floor(deviation * gain / 16), where gain is an 8-bit unsigned value with 4 fractional bits, and the result is clamped to [-512, 511].
- R3: If the sum input is strictly below the cutoff, the kick is 0 for every law. A sum equal to the cutoff passes the law value through.
- R4: With law code 2 (bang-bang), the kick is +511 for a positive deviation, -512 for a negative deviation and 0 for a zero deviation.
- R5: With law code 3 (bang-bang with deadband), the kick is 0 while |deviation| <= deadband. Outside the deadband it follows R4.
- R6: A sample taken at a rising clock edge appears on the kick output after 1 + out_delay rising edges, with out_delay in the range 0 to 31.
- R7: The complementary output is the negation of the kick. A kick of -512 gives +511 on the complementary output.
- R8: Before the first cycle_start pulse after reset, law_a applies. Take the cycle in which cycle_start is high as cycle 0. Cycles 1 to switch_time use law_a, and law_b applies from cycle switch_time+1 onward. Each new pulse restarts the timer.
- R9: While reset is held, and right after it is released, both outputs are 0. The whole delay line is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_in | input | 12 | Signed orbit deviation of the current bunch |
| sum_in | input | 10 | Unsigned bunch sum signal |
| sum_cutoff | input | 10 | Minimum sum for which a kick is issued |
| law_a | input | 2 | Law selection used before the switch time (0 direct, 1 scaled, 2 bang-bang, 3 deadband) |
| law_b | input | 2 | Law selection used after the switch time |
| switch_time | input | 24 | Clocks after cycle_start before law_b takes over |
| cycle_start | input | 1 | One-clock pulse that marks the start of an accelerator cycle |
| gain | input | 8 | Unsigned gain for the scaled law, 4 fractional bits |
| deadband | input | 11 | Deadband half-width for law 3 |
| out_delay | input | 5 | Bunch alignment delay in clocks |
| kick | output | 10 | Signed kick code |
| kick_n | output | 10 | Complementary signed kick code |

## Verification
The bench targets these boundaries:
- Clamping at +511 and -512 in both linear laws. A design that wraps instead of saturating would send a full-scale kick in the wrong direction.
- Rounding of a negative fractional product. It must floor to -3, where truncation toward zero would give -2.
- The deadband edges at exactly ±deadband and one step beyond.
- The cutoff at sum equal to the threshold.
- Negation of -512 on the complementary output. Without saturation it would come out as -512, with the wrong polarity.
- The law change, checked to the exact cycle, including a restart from an already switched state.
- The delay at 5 and at the maximum of 31, where an off-by-one would hit the neighbouring bunch.
- A mid-run reset. If the reset left the delay line full, stale kicks would be released afterward.

// File: rtl/kick_law_stage.sv
module kick_law_stage #(
  parameter int DEV_W     = 12,
  parameter int SUM_W     = 10,
  parameter int KICK_W    = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  parameter int DLY_W     = 5,
  parameter int TIME_W    = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DEV_W-1:0]  dev_in,
  input  logic        [SUM_W-1:0]  sum_in,
  input  logic        [SUM_W-1:0]  sum_cutoff,
  input  logic        [1:0]        law_a,
  input  logic        [1:0]        law_b,
  input  logic        [TIME_W-1:0] switch_time,
  input  logic                     cycle_start,
  input  logic        [GAIN_W-1:0] gain,
  input  logic        [DEV_W-2:0]  deadband,
  input  logic        [DLY_W-1:0]  out_delay,
  output logic signed [KICK_W-1:0] kick,
  output logic signed [KICK_W-1:0] kick_n
);

  localparam int DEPTH  = 1 << DLY_W;
  localparam int PROD_W = DEV_W + GAIN_W + 1;
  localparam logic signed [KICK_W-1:0] K_MAX = {1'b0, {(KICK_W-1){1'b1}}};
  localparam logic signed [KICK_W-1:0] K_MIN = {1'b1, {(KICK_W-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] P_MAX = PROD_W'((2 ** (KICK_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] P_MIN = PROD_W'(-(2 ** (KICK_W-1)));

  function automatic logic signed [KICK_W-1:0] clamp(input logic signed [PROD_W-1:0] v);
    if (v > P_MAX)      return K_MAX;
    else if (v < P_MIN) return K_MIN;
    else                return v[KICK_W-1:0];
  endfunction

  logic                     armed;
  logic        [TIME_W-1:0] cyc_cnt;
  logic        [1:0]        law_sel;
  logic signed [PROD_W-1:0] dev_wide, prod, scaled;
  logic        [DEV_W-1:0]  dev_mag;
  logic signed [KICK_W-1:0] bang, law_val, gated;
  logic signed [KICK_W-1:0] pipe [DEPTH];
  logic signed [KICK_W-1:0] stage_q;

  assign law_sel  = (armed && cyc_cnt >= switch_time) ? law_b : law_a;
  assign dev_wide = PROD_W'(dev_in);
  assign prod     = dev_wide * $signed({1'b0, gain});
  assign scaled   = prod >>> GAIN_FRAC;
  assign dev_mag  = dev_in[DEV_W-1] ? DEV_W'(-dev_in) : DEV_W'(dev_in);
  assign bang     = (dev_in > 0) ? K_MAX : (dev_in < 0) ? K_MIN : '0;

  always_comb begin
    case (law_sel)
      2'd0:    law_val = clamp(dev_wide);
      2'd1:    law_val = clamp(scaled);
      2'd2:    law_val = bang;
      default: law_val = (dev_mag <= {1'b0, deadband}) ? '0 : bang;
    endcase
  end

  assign gated = (sum_in < sum_cutoff) ? '0 : law_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cyc_cnt <= '0;
    end else if (cycle_start) begin
      armed   <= 1'b1;
      cyc_cnt <= '0;
    end else if (cyc_cnt != '1) begin
      cyc_cnt <= cyc_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= gated;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign stage_q = pipe[0];
  assign kick    = pipe[out_delay];
  assign kick_n  = (kick == K_MIN) ? K_MAX : -kick;

endmodule

// File: rtl/kick_law_stage_chk.sv
module kick_law_stage_chk #(
  parameter int SUM_W  = 10,
  parameter int KICK_W = 10,
  parameter int DLY_W  = 5,
  parameter int TIME_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic        [SUM_W-1:0]  sum_in,
  input logic        [SUM_W-1:0]  sum_cutoff,
  input logic        [DLY_W-1:0]  out_delay,
  input logic                     cycle_start,
  input logic        [1:0]        law_sel,
  input logic                     armed,
  input logic        [TIME_W-1:0] cyc_cnt,
  input logic signed [KICK_W-1:0] stage_q,
  input logic signed [KICK_W-1:0] kick,
  input logic signed [KICK_W-1:0] kick_n
);

  localparam logic signed [KICK_W-1:0] K_MAX = {1'b0, {(KICK_W-1){1'b1}}};
  localparam logic signed [KICK_W-1:0] K_MIN = {1'b1, {(KICK_W-1){1'b0}}};

  assert_cutoff_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sum_in < sum_cutoff) && out_delay == '0) |-> kick == '0);

  assert_bang_levels_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(law_sel[1]) |-> (stage_q == K_MAX || stage_q == K_MIN || stage_q == '0));

  assert_delay_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_delay == DLY_W'(2)) |-> kick == $past(stage_q, 2));

  assert_pushpull_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kick != K_MIN) |-> KICK_W'(kick + kick_n) == '0);

  assert_pushpull_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kick == K_MIN) |-> kick_n == K_MAX);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> (armed && cyc_cnt == '0));

endmodule

bind kick_law_stage kick_law_stage_chk #(
  .SUM_W(SUM_W), .KICK_W(KICK_W), .DLY_W(DLY_W), .TIME_W(TIME_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .sum_cutoff(sum_cutoff),
  .out_delay(out_delay), .cycle_start(cycle_start), .law_sel(law_sel),
  .armed(armed), .cyc_cnt(cyc_cnt), .stage_q(stage_q), .kick(kick), .kick_n(kick_n)
);

// File: tb/tb_kick_law_stage.sv
`timescale 1ns/1ps
module tb_kick_law_stage;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [11:0] dev_in = '0;
  logic        [9:0]  sum_in = '0;
  logic        [9:0]  sum_cutoff = 10'd100;
  logic        [1:0]  law_a = '0;
  logic        [1:0]  law_b = 2'd3;
  logic        [23:0] switch_time = '0;
  logic               cycle_start = 1'b0;
  logic        [7:0]  gain = 8'd16;
  logic        [10:0] deadband = 11'd10;
  logic        [4:0]  out_delay = '0;
  logic signed [9:0]  kick, kick_n;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  kick_law_stage dut (
    .clk(clk), .rst_n(rst_n), .dev_in(dev_in), .sum_in(sum_in), .sum_cutoff(sum_cutoff),
    .law_a(law_a), .law_b(law_b), .switch_time(switch_time), .cycle_start(cycle_start),
    .gain(gain), .deadband(deadband), .out_delay(out_delay), .kick(kick), .kick_n(kick_n)
  );

  localparam int NV = 21;
  localparam int V_LAW  [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 2, 2, 2, 3, 3, 3, 3, 0, 0, 2, 1};
  localparam int V_DEV  [NV] = '{37, -300, 900, -2048, 100, -7, -5, 400, -2048, 50,
                                 1, -1, 0, 10, 11, -10, -11, 200, 200, 5, -1000};
  localparam int V_SUM  [NV] = '{200, 200, 200, 200, 200, 200, 200, 200, 200, 200,
                                 200, 200, 200, 200, 200, 200, 200, 99, 100, 0, 100};
  localparam int V_GAIN [NV] = '{16, 16, 16, 16, 24, 16, 8, 32, 255, 0,
                                 16, 16, 16, 16, 16, 16, 16, 16, 16, 16, 16};
  localparam int V_EXP  [NV] = '{37, -300, 511, -512, 150, -7, -3, 511, -512, 0,
                                 511, -512, 0, 0, 511, 0, -512, 0, 200, 0, -512};
  string V_REQ [NV] = '{"R1", "R1", "R1", "R1", "R2", "R2", "R2", "R2", "R2", "R2",
                        "R4", "R4", "R4", "R5", "R5", "R5", "R5", "R3", "R3", "R3", "R3"};

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    dev_in = 12'sd300;
    sum_in = 10'd200;
    repeat (3) @(negedge clk);
    chk("R9", "kick in reset", int'(kick), 0);
    chk("R9", "kick_n in reset", int'(kick_n), 0);
    rst_n = 1'b1;

    // Vector walk: no cycle_start yet, so law_a applies (R8) even though law_b differs
    for (int i = 0; i < NV; i++) begin
      law_a  = V_LAW[i][1:0];
      dev_in = V_DEV[i][11:0];
      sum_in = V_SUM[i][9:0];
      gain   = V_GAIN[i][7:0];
      @(negedge clk);
      chk(V_REQ[i], $sformatf("kick vec %0d", i), int'(kick), V_EXP[i]);
      chk("R7", $sformatf("kick_n vec %0d", i), int'(kick_n),
          (V_EXP[i] == -512) ? 511 : -V_EXP[i]);
    end

    // R6: alignment delay of 5 and 31
    law_a = 2'd0; sum_in = 10'd200;
    for (int d = 5; d <= 31; d += 26) begin
      out_delay = 5'(d);
      dev_in = '0;
      repeat (40) @(negedge clk);
      dev_in = 12'sd123;
      @(negedge clk);
      dev_in = '0;
      for (int m = 2; m <= d + 2; m++) begin
        @(negedge clk);
        if (m == d)     chk("R6", $sformatf("before, delay %0d", d), int'(kick), 0);
        if (m == d + 1) chk("R6", $sformatf("on time, delay %0d", d), int'(kick), 123);
        if (m == d + 2) chk("R6", $sformatf("after, delay %0d", d), int'(kick), 0);
      end
    end

    // R8: timed law change, direct -> bang-bang after 3 clocks
    out_delay = '0; law_a = 2'd0; law_b = 2'd2; switch_time = 24'd3;
    dev_in = 12'sd5;
    @(negedge clk);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    chk("R8", "cycle 0", int'(kick), 5);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R8", $sformatf("cycle %0d", k), int'(kick), 5);
    end
    @(negedge clk);
    chk("R8", "cycle 4 switched", int'(kick), 511);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    chk("R8", "restart pulse cycle", int'(kick), 511);
    @(negedge clk);
    chk("R8", "restart cycle 1", int'(kick), 5);

    // R9: mid-run reset clears the whole delay line
    law_a = 2'd0; law_b = 2'd0; out_delay = 5'd31; dev_in = 12'sd77;
    repeat (40) @(negedge clk);
    chk("R9", "line filled", int'(kick), 77);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9", "kick during reset", int'(kick), 0);
    dev_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "line cleared after reset", int'(kick), 0);
    chk("R9", "kick_n after reset", int'(kick_n), 0);

    summary();
    $finish;
  end

endmodule